// File: doc/BRIEF.md
# Processor Interrupt Interface with Split End-of-Interrupt

This block is the per-processor side of an interrupt controller. A few interrupt sources feed it pulses that latch as pending. Each source has a programmable priority and an enable bit. The block raises an interrupt request whenever the best eligible source beats both the running priority and a programmable priority mask. Software talks to it over a simple register bus.

- Reading the acknowledge register takes the best source. It becomes active, and its priority is pushed onto a running-priority stack.
- Writing the end-of-interrupt register releases the priority again.

A control bit selects one of two completion styles:

- **Combined:** the end-of-interrupt write drops the priority and deactivates the source in one step.
- **Split:** the end-of-interrupt write only drops the priority. The source stays active until its ID is written to a deactivate register in the upper 4 KB page of an 8 KB window. A parameter can remove that page, which leaves the interface with the combined style only.

Source numbering:

- Sources below `NUM_SGI` carry the inter-processor IDs 0, 1, …
- The remaining sources carry peripheral IDs from 16 upward.
- IDs 1020 and above never name a source.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the following hold:
  - `irq_out` is 0.
  - The control register (byte offset 0x000) reads 0.
  - The priority mask (0x004) reads 0.
  - The running priority (0x014) reads all ones (0xFF).
  - No source is pending or active.
- R2: `irq_out` is 1 only when all of these hold:
  - the control enable bit is set;
  - some source is pending, enabled and not active;
  - its priority value is numerically lower than both the running priority and the mask.
- R3: A read of the acknowledge register (0x00C) returns, in bits [9:0], the ID of the eligible source with the numerically lowest priority, taking the lower source index on a tie. In the same step the source moves from pending to active, and its priority becomes the running priority.
- R4: An acknowledge read with no eligible source returns 1023 and changes no state.
- R5: An end-of-interrupt write (0x010, ID in bits [9:0]) takes effect only if the ID names the most recently acknowledged source that has not yet been released. Any other ID, including the reserved values 1020 and above, is ignored.
- R6: With the split bit (control bit 9) at 0, a valid end-of-interrupt write restores the previous running priority and makes the source inactive, so a new pulse on it can be taken again.
- R7: With the split bit at 1, a valid end-of-interrupt write restores the previous running priority and leaves the source active. Other sources of the same priority may then be signalled, but the still-active source is never presented.
- R8: With the split bit at 1, writing a source ID to the deactivate register (byte offset 0x1000) makes that source inactive.
- R9: Source index i carries ID i when i < `NUM_SGI`, and ID 16 + i − `NUM_SGI` otherwise.
- R10: The control register and the per-source registers read back what was written:
  - Control: bit 0 is enable, bits [8:5] are the bypass-disable bits, bit 9 is split.
  - Per-source register at 0x100 + 4·i: bits [7:0] are the priority, bit 31 is the enable.
- R11: With `HAS_DIR` = 0, the split bit always reads 0, and writes anywhere in the upper page (address bit 12 set) have no effect. End-of-interrupt then always deactivates the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SGI+NUM_PER | Per-source pulse that sets the pending state |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bench builds two instances with two inter-processor sources and four peripheral sources. The first has the deactivate page (`HAS_DIR` = 1), which brings nesting, split-mode same-priority handoff and explicit deactivation within reach. The second has `HAS_DIR` = 0, showing that the split bit cannot be set and that the upper page is inert. Six sources are enough to nest two levels, to tie two sources at one priority, to keep one source disabled, and to cover both ID ranges.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int FIRST_PER_ID = 16;

  // byte offsets inside a 4 KB page
  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_PMASK = 12'h004;
  localparam logic [11:0] OFF_ACK   = 12'h00C;
  localparam logic [11:0] OFF_EOI   = 12'h010;
  localparam logic [11:0] OFF_RPRI  = 12'h014;
  localparam logic [11:0] OFF_PRIO  = 12'h100;
  localparam logic [11:0] OFF_DEACT = 12'h000; // in the upper page

  localparam int CTRL_EN     = 0;
  localparam int CTRL_BYP_LO = 5;
  localparam int CTRL_BYP_W  = 4;
  localparam int CTRL_SPLIT  = 9;

  function automatic logic [ID_W-1:0] src_id(input int idx, input int nsgi);
    return (idx < nsgi) ? ID_W'(idx) : ID_W'(FIRST_PER_ID + idx - nsgi);
  endfunction
endpackage

// File: rtl/icpu_arbiter.sv
module icpu_arbiter #(
  parameter int N      = 6,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]             cand,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     valid,
  output logic [IDX_W-1:0]         idx,
  output logic [PRIO_W-1:0]        best_prio
);
  // strict compare keeps the lower index on equal priority
  always_comb begin
    valid     = 1'b0;
    idx       = '0;
    best_prio = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || prio[i] < best_prio)) begin
        valid     = 1'b1;
        idx       = IDX_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/icpu_prio_stack.sv
module icpu_prio_stack #(
  parameter int DEPTH  = 6,
  parameter int IDX_W  = 3,
  parameter int PRIO_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic              empty,
  output logic [IDX_W-1:0]  top_idx,
  output logic [PRIO_W-1:0] top_prio,
  output logic [LVL_W-1:0]  level
);
  localparam int SLOTS = 1 << AW;

  logic [IDX_W-1:0]  idx_mem  [SLOTS];
  logic [PRIO_W-1:0] prio_mem [SLOTS];
  logic [AW-1:0]     wr_addr, rd_addr;
  logic              do_push;

  assign wr_addr = AW'(level);
  assign rd_addr = AW'(level - 1'b1);
  assign do_push = push && (level < LVL_W'(DEPTH));
  assign empty   = (level == '0);

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) begin
      idx_mem[wr_addr]  <= push_idx;
      prio_mem[wr_addr] <= push_prio;
    end
  end

  assign top_idx  = idx_mem[rd_addr];
  assign top_prio = prio_mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst)                level <= '0;
    else if (do_push)       level <= level + 1'b1;
    else if (pop && !empty) level <= level - 1'b1;
  end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import icpu_pkg::*;
#(
  parameter int NUM_SGI = 2,
  parameter int NUM_PER = 4,
  parameter int PRIO_W  = 8,
  parameter int HAS_DIR = 1,
  parameter int ADDR_W  = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SGI+NUM_PER-1:0] irq_in,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       irq_out
);
  localparam int NUM_SRC = NUM_SGI + NUM_PER;
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LVL_W   = $clog2(NUM_SRC + 1);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

  logic [11:0] off;
  logic        hi_page;
  assign off     = bus_addr[11:0];
  assign hi_page = bus_addr[12];

  logic                      ctrl_en_q, split_q;
  logic [CTRL_BYP_W-1:0]     byp_q;
  logic [PRIO_W-1:0]         pmask_q;
  logic [NUM_SRC-1:0]        pend_q, act_q, src_en_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

  logic wr_ctrl, wr_pmask, wr_eoi, wr_deact, rd_ack;
  assign wr_ctrl  = bus_wr && !hi_page && off == OFF_CTRL;
  assign wr_pmask = bus_wr && !hi_page && off == OFF_PMASK;
  assign wr_eoi   = bus_wr && !hi_page && off == OFF_EOI;
  assign rd_ack   = bus_rd && !hi_page && off == OFF_ACK;

  generate
    if (HAS_DIR != 0) begin : g_dir
      assign wr_deact = bus_wr && hi_page && off == OFF_DEACT;
    end else begin : g_nodir
      assign wr_deact = 1'b0;
    end
  endgenerate

  // best candidate among pending, enabled, not active
  logic              best_valid;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;

  icpu_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .cand(pend_q & src_en_q & ~act_q), .prio(prio_q),
    .valid(best_valid), .idx(best_idx), .best_prio(best_prio)
  );

  logic              stk_empty, ack_take, eoi_pop, eligible;
  logic [IDX_W-1:0]  top_idx;
  logic [PRIO_W-1:0] top_prio, rpri;
  logic [LVL_W-1:0]  level;

  icpu_prio_stack #(.DEPTH(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst(rst),
    .push(ack_take), .push_idx(best_idx), .push_prio(best_prio),
    .pop(eoi_pop), .empty(stk_empty), .top_idx(top_idx),
    .top_prio(top_prio), .level(level)
  );

  assign rpri     = stk_empty ? PRIO_IDLE : top_prio;
  assign eligible = ctrl_en_q && best_valid && best_prio < rpri && best_prio < pmask_q;
  assign ack_take = rd_ack && eligible;

  // map the written ID back to a source index
  logic             id_hit;
  logic [IDX_W-1:0] id_idx;
  always_comb begin
    id_hit = 1'b0;
    id_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_wdata[ID_W-1:0] == src_id(i, NUM_SGI)) begin
        id_hit = 1'b1;
        id_idx = IDX_W'(i);
      end
    end
  end

  assign eoi_pop = wr_eoi && !stk_empty && id_hit && id_idx == top_idx;

  logic [NUM_SRC-1:0] take_vec, clr_vec;
  always_comb begin
    take_vec = '0;
    clr_vec  = '0;
    if (ack_take) take_vec[best_idx] = 1'b1;
    if (eoi_pop && !split_q) clr_vec[top_idx] = 1'b1;
    if (wr_deact && split_q && id_hit) clr_vec[id_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en_q <= 1'b0;
      split_q   <= 1'b0;
      byp_q     <= '0;
      pmask_q   <= '0;
      pend_q    <= '0;
      act_q     <= '0;
      src_en_q  <= '0;
      prio_q    <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en_q <= bus_wdata[CTRL_EN];
        byp_q     <= bus_wdata[CTRL_BYP_LO +: CTRL_BYP_W];
        split_q   <= (HAS_DIR != 0) && bus_wdata[CTRL_SPLIT];
      end
      if (wr_pmask) pmask_q <= bus_wdata[PRIO_W-1:0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_wr && !hi_page && off == 12'(OFF_PRIO + 4 * i)) begin
          prio_q[i]   <= bus_wdata[PRIO_W-1:0];
          src_en_q[i] <= bus_wdata[31];
        end
      end
      pend_q  <= (pend_q & ~take_vec) | irq_in;
      act_q   <= (act_q | take_vec) & ~clr_vec;
      irq_out <= eligible;
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (!hi_page) begin
      if (off == OFF_CTRL) begin
        rd_mux[CTRL_EN]                    = ctrl_en_q;
        rd_mux[CTRL_BYP_LO +: CTRL_BYP_W]  = byp_q;
        rd_mux[CTRL_SPLIT]                 = split_q;
      end
      if (off == OFF_PMASK) rd_mux[PRIO_W-1:0] = pmask_q;
      if (off == OFF_RPRI)  rd_mux[PRIO_W-1:0] = rpri;
      if (off == OFF_ACK)
        rd_mux[ID_W-1:0] = ack_take ? src_id(int'(best_idx), NUM_SGI) : SPURIOUS_ID;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (off == 12'(OFF_PRIO + 4 * i)) begin
          rd_mux[PRIO_W-1:0] = prio_q[i];
          rd_mux[31]         = src_en_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[30:ID_W];
endmodule

// File: rtl/icpu_checker.sv
module icpu_checker #(
  parameter int N     = 6,
  parameter int IDX_W = 3,
  parameter int LVL_W = 3,
  parameter int DEPTH = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_ack,
  input logic             ack_take,
  input logic             eoi_pop,
  input logic             split,
  input logic [N-1:0]     act,
  input logic [N-1:0]     take_vec,
  input logic [IDX_W-1:0] top_idx,
  input logic [LVL_W-1:0] level
);
  logic [IDX_W-1:0] popped_q;
  always_ff @(posedge clk) popped_q <= top_idx;

  a_r3_ack_pushes: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> level == $past(level) + 1'b1);

  a_r3_single_take: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_vec));

  a_r4_spurious_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !ack_take) |=> ($stable(level) && $stable(act)));

  a_r5_stack_bounded: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  a_r6_combined_deactivates: assert property (@(posedge clk) disable iff (rst)
    (eoi_pop && !split) |=> !act[popped_q]);

  a_r7_split_keeps_active: assert property (@(posedge clk) disable iff (rst)
    (eoi_pop && split) |=> $stable(act));
endmodule

bind irq_cpu_if icpu_checker #(
  .N(NUM_SRC), .IDX_W(IDX_W), .LVL_W(LVL_W), .DEPTH(NUM_SRC)
) u_chk (
  .clk(clk), .rst(rst), .rd_ack(rd_ack), .ack_take(ack_take),
  .eoi_pop(eoi_pop), .split(split_q), .act(act_q), .take_vec(take_vec),
  .top_idx(top_idx), .level(level)
);

// File: tb/tb_irq_cpu_if.sv
module tb_irq_cpu_if;
  localparam int NSRC = 6;
  localparam logic [12:0] A_CTRL = 13'h000, A_PMASK = 13'h004, A_ACK = 13'h00C,
                          A_EOI = 13'h010, A_RPRI = 13'h014, A_DEACT = 13'h1000;
  function automatic logic [12:0] a_prio(input int i);
    return 13'(13'h100 + 4 * i);
  endfunction

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [NSRC-1:0] irq_in = '0, k_irq_in = '0;
  logic [12:0] addr = '0, k_addr = '0;
  logic wr = 1'b0, rd = 1'b0, k_wr = 1'b0, k_rd = 1'b0;
  logic [31:0] wdata = '0, k_wdata = '0, rdata, k_rdata;
  logic irq, k_irq;

  irq_cpu_if #(.NUM_SGI(2), .NUM_PER(4), .HAS_DIR(1)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq));

  irq_cpu_if #(.NUM_SGI(2), .NUM_PER(4), .HAS_DIR(0)) dut4k (
    .clk(clk), .rst(rst), .irq_in(k_irq_in), .bus_addr(k_addr), .bus_wr(k_wr),
    .bus_rd(k_rd), .bus_wdata(k_wdata), .bus_rdata(k_rdata), .irq_out(k_irq));

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per read strobe
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen === 1'b1 && exp_q.size() > 0) begin
      check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [12:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); irq_in[i] = 1'b1;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    repeat (3) @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, e});
  endtask

  task automatic k_wr_reg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); k_addr = a; k_wdata = d; k_wr = 1'b1;
    @(negedge clk); k_wr = 1'b0;
  endtask

  task automatic k_rd_chk(input logic [12:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); k_addr = a; k_rd = 1'b1;
    @(negedge clk); k_rd = 1'b0;
    check(tag, k_rdata, e);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_out after reset", {31'b0, irq}, 32'h0);
    rd_exp(A_CTRL, 32'h0, "R1 ctrl reset");
    rd_exp(A_PMASK, 32'h0, "R1 mask reset");
    rd_exp(A_RPRI, 32'hFF, "R1 running prio reset");
    rd_exp(A_ACK, 32'd1023, "R4 spurious after reset");

    // R10 configuration readback
    wr_reg(A_CTRL, 32'h1E1);
    rd_exp(A_CTRL, 32'h1E1, "R10 ctrl readback");
    wr_reg(A_PMASK, 32'hFF);
    wr_reg(a_prio(0), 32'h8000_0060);
    wr_reg(a_prio(1), 32'h8000_0050);
    wr_reg(a_prio(2), 32'h8000_0040);
    wr_reg(a_prio(3), 32'h8000_0040);
    wr_reg(a_prio(4), 32'h8000_0020);
    wr_reg(a_prio(5), 32'h0000_0010);
    rd_exp(a_prio(2), 32'h8000_0040, "R10 prio readback");

    // combined mode, nesting (R2 R3 R5 R6)
    pulse(2);
    irq_chk(1'b1, "R2 pending source signalled");
    rd_exp(A_ACK, 32'd16, "R3 ack returns ID16");
    rd_exp(A_RPRI, 32'h40, "R3 running prio raised");
    irq_chk(1'b0, "R2 no request after ack");
    pulse(2);
    irq_chk(1'b0, "R2 active source not signalled");
    pulse(4);
    irq_chk(1'b1, "R2 higher priority preempts");
    rd_exp(A_ACK, 32'd18, "R3 nested ack ID18");
    rd_exp(A_RPRI, 32'h20, "R3 nested running prio");
    wr_reg(A_EOI, 32'd16);
    rd_exp(A_RPRI, 32'h20, "R5 out-of-order eoi ignored");
    wr_reg(A_EOI, 32'd18);
    rd_exp(A_RPRI, 32'h40, "R5 eoi pops to previous");
    irq_chk(1'b0, "R2 src still active");
    wr_reg(A_EOI, 32'd16);
    rd_exp(A_RPRI, 32'hFF, "R6 eoi restores idle");
    irq_chk(1'b1, "R6 combined eoi deactivates");
    rd_exp(A_ACK, 32'd16, "R6 retaken after eoi");
    wr_reg(A_EOI, 32'd16);
    irq_chk(1'b0, "R6 quiet after final eoi");

    // disabled source (R2 R4)
    pulse(5);
    irq_chk(1'b0, "R2 disabled source ignored");
    rd_exp(A_ACK, 32'd1023, "R4 spurious for disabled");
    rd_exp(A_RPRI, 32'hFF, "R4 no state change");

    // priority mask and enable (R2)
    wr_reg(A_PMASK, 32'h40);
    pulse(3);
    irq_chk(1'b0, "R2 equal to mask blocked");
    rd_exp(A_ACK, 32'd1023, "R4 masked gives spurious");
    wr_reg(A_PMASK, 32'h41);
    irq_chk(1'b1, "R2 below mask signalled");
    wr_reg(A_CTRL, 32'h1E0);
    irq_chk(1'b0, "R2 disabled interface quiet");
    rd_exp(A_ACK, 32'd1023, "R4 disabled interface spurious");
    wr_reg(A_CTRL, 32'h1E1);
    rd_exp(A_ACK, 32'd17, "R3 ack ID17");
    wr_reg(A_EOI, 32'd17);
    wr_reg(A_PMASK, 32'hFF);

    // split mode (R7 R8 R3 tie)
    wr_reg(A_CTRL, 32'h3E1);
    rd_exp(A_CTRL, 32'h3E1, "R10 split bit readback");
    pulse(2);
    pulse(3);
    rd_exp(A_ACK, 32'd16, "R3 tie goes to lower index");
    irq_chk(1'b0, "R2 same priority not preempting");
    wr_reg(A_EOI, 32'd1020);
    rd_exp(A_RPRI, 32'h40, "R5 reserved ID ignored");
    wr_reg(A_EOI, 32'd16);
    rd_exp(A_RPRI, 32'hFF, "R7 split eoi drops priority");
    irq_chk(1'b1, "R7 same level now signalled");
    pulse(2);
    rd_exp(A_ACK, 32'd17, "R7 active source skipped");
    wr_reg(A_EOI, 32'd17);
    irq_chk(1'b0, "R7 dropped but active not presented");
    rd_exp(A_ACK, 32'd1023, "R7 spurious while both active");
    wr_reg(A_DEACT, 32'd16);
    irq_chk(1'b1, "R8 deactivate frees source");
    rd_exp(A_ACK, 32'd16, "R8 retaken after deactivate");
    wr_reg(A_EOI, 32'd16);
    wr_reg(A_DEACT, 32'd16);
    wr_reg(A_DEACT, 32'd17);
    irq_chk(1'b0, "R8 all idle");
    rd_exp(A_ACK, 32'd1023, "R4 spurious at end of split");

    // ID map (R9)
    wr_reg(A_CTRL, 32'h1E1);
    pulse(0);
    rd_exp(A_ACK, 32'd0, "R9 source0 ID0");
    rd_exp(A_RPRI, 32'h60, "R9 source0 priority");
    wr_reg(A_EOI, 32'd0);
    pulse(1);
    rd_exp(A_ACK, 32'd1, "R9 source1 ID1");
    wr_reg(A_EOI, 32'd1);
    rd_exp(A_RPRI, 32'hFF, "R9 idle after SGI eoi");

    // 4 KB variant (R11)
    k_rd_chk(A_CTRL, 32'h0, "R1 4k ctrl reset");
    k_wr_reg(A_CTRL, 32'h3E1);
    k_rd_chk(A_CTRL, 32'h1E1, "R11 split bit stuck at 0");
    k_wr_reg(A_PMASK, 32'hFF);
    k_wr_reg(a_prio(2), 32'h8000_0040);
    @(negedge clk); k_irq_in[2] = 1'b1;
    @(negedge clk); k_irq_in = '0;
    k_rd_chk(A_ACK, 32'd16, "R11 4k ack");
    k_wr_reg(A_DEACT, 32'h201);
    k_rd_chk(A_CTRL, 32'h1E1, "R11 upper page write inert");
    k_wr_reg(A_EOI, 32'd16);
    k_rd_chk(A_RPRI, 32'hFF, "R11 eoi drops");
    @(negedge clk); k_irq_in[2] = 1'b1;
    @(negedge clk); k_irq_in = '0;
    repeat (3) @(negedge clk);
    check("R11 eoi deactivates in 4k", {31'b0, k_irq}, 32'h1);
    k_rd_chk(A_ACK, 32'd16, "R11 retaken");

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule